// File: doc/BRIEF.md
# Page-Mode Extended-Data-Out DRAM Controller

This block is a synchronous controller for a 128K-word by 32-bit dynamic RAM with extended data out and one column strobe per byte lane. A host presents a word address, a byte-enable nibble, write data and a write flag through a valid/ready handshake. The controller produces the row strobe, the four column strobes, the write strobe, the output enable and the shared nine-bit multiplexed address.

A row stays open after an access. Later requests to the same row are served with column cycles only. A request to another row closes the current row first. A row that has been open for the configured page limit is also closed, at the next request boundary. An external refresh request closes the open row, blocks new requests, and runs one column-before-row refresh cycle that is answered with a one-cycle acknowledge.

Read data is captured after the column strobe has risen again. This relies on the extended output hold of the memory. All memory timings are parameters counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The 17-bit word address splits into row = addr[16:8] and column = addr[7:0]. The row is on `mem_a` when the row strobe falls. The column, zero-extended to 9 bits, is on `mem_a` when the column strobes fall.
- R2: Column strobe `mem_col_stb_n[i]` goes low in an access only when `req_be[i]` is 1. Lane i is data bits [8i+7:8i]. A write changes only the enabled lanes. A read returns zero in the lanes that are not enabled.
- R3: A write is an early write. `mem_wr_n` is low at least one cycle before the column strobes fall and stays low while they are low. The controller drives `mem_d_out` (`mem_d_drive`=1) only in writes, and `mem_rd_en_n` stays high while it drives.
- R4: A request to the open row, with the page limit not reached, is accepted without a new row strobe cycle.
- R5: A request to a different row first raises the row strobe for at least PRECH_CYC cycles, then opens the new row.
- R6: Read data is sampled after the column strobes have risen. `rd_valid` is a one-cycle pulse per read.
- R7: A row open for PAGE_LIMIT_CYC cycles is closed at the next request boundary, even with no request pending. The row strobe never stays low longer than PAGE_LIMIT_CYC+CAS_LOW_CYC+CAS_HIGH_CYC+4 cycles.
- R8: `ref_req` closes the open row and then performs a refresh. All column strobes fall while the row strobe is high, the row strobe then falls, and `ref_ack` pulses once. The next access needs a new row opening.
- R9: While `ref_req` is high and not yet acknowledged, `req_ready` is low.
- R10: During and right after reset, all strobes are high, `mem_d_drive` and `rd_valid` are 0, and `req_ready` is 1.
- R11: On a row opening, the first column strobe falls RAS2CAS_CYC+1 cycles after the row strobe. The column strobes stay low for CAS_LOW_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 17 | Word address {row, column} |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh request, held until acknowledged |
| ref_ack | output | 1 | Refresh done pulse |
| mem_row_stb_n | output | 1 | Row address strobe, active low |
| mem_col_stb_n | output | 4 | Per-lane column address strobes, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_en_n | output | 1 | Output enable, active low |
| mem_a | output | 9 | Multiplexed row/column address |
| mem_d_out | output | 32 | Data to memory |
| mem_d_drive | output | 1 | Controller drives the data bus |
| mem_d_in | input | 32 | Data from memory |

## Verification
The assertions assume that the memory holds read data from the column strobe fall until the strobe falls again, the row strobe rises or the output enable rises. They also assume that `ref_req` is held high until `ref_ack`. The bench memory model updates at falling clock edges: it latches the row on a row-strobe fall and the column on a column-strobe fall, and it keeps the lanes it drives stable in between, so it meets the hold assumption. The bench holds `ref_req` and a competing request together until the acknowledge and drops both at that point, so the handshake assumptions are met.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_CSET,
    ST_COL,
    ST_CPRE,
    ST_OPEN,
    ST_PRE,
    ST_RF_SETUP,
    ST_RF_LOW,
    ST_RF_REC
  } ctl_state_e;

  // cycles-to-count-value: a phase of n cycles loads n-1
  function automatic int unsigned span_to_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic logic row_is_low(input ctl_state_e s);
    return (s == ST_ACT) || (s == ST_CSET) || (s == ST_COL) ||
           (s == ST_CPRE) || (s == ST_OPEN) || (s == ST_RF_LOW);
  endfunction

  function automatic logic page_running(input ctl_state_e s);
    return (s == ST_ACT) || (s == ST_CSET) || (s == ST_COL) ||
           (s == ST_CPRE) || (s == ST_OPEN);
  endfunction

endpackage

// File: rtl/edo_down_timer.sv
module edo_down_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/edo_page_timer.sv
module edo_page_timer #(
  parameter int LIMIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] LIM = PW'(LIMIT);
  logic [PW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           age_q <= '0;
    else if (!run)        age_q <= '0;
    else if (age_q != LIM) age_q <= age_q + 1'b1;
  end

  assign expired = (age_q == LIM);
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int ROW_W = 9,
  parameter int COL_W = 8,
  parameter int MA_W  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W+COL_W-1:0] in_addr,
  input  logic                   cmd_latch,
  input  logic                   open_set,
  input  logic                   open_clr,
  output logic [MA_W-1:0]        open_row,
  output logic [MA_W-1:0]        cur_col,
  output logic                   hit
);
  localparam int ADDR_W = ROW_W + COL_W;

  function automatic logic [ROW_W-1:0] row_field(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_field(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cmd_latch) col_q <= col_field(in_addr);
      if (open_set) begin
        row_q   <= row_field(in_addr);
        valid_q <= 1'b1;
      end else if (open_clr) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign open_row = MA_W'(row_q);
  assign cur_col  = MA_W'(col_q);
  assign hit      = valid_q && (row_field(in_addr) == row_q);

  // a hit is only ever reported against a row that was opened
  AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid_q && !$past(open_clr)); // R4
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W          = 9,
  parameter int COL_W          = 8,
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 8,
  parameter int RAS2CAS_CYC    = 2,
  parameter int CAS_LOW_CYC    = 2,
  parameter int CAS_HIGH_CYC   = 1,
  parameter int PRECH_CYC      = 3,
  parameter int CBR_SETUP_CYC  = 1,
  parameter int REF_LOW_CYC    = 4,
  parameter int PAGE_LIMIT_CYC = 120
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W/8-1:0]    req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_req,
  output logic                   ref_ack,
  output logic                   mem_row_stb_n,
  output logic [DATA_W/8-1:0]    mem_col_stb_n,
  output logic                   mem_wr_n,
  output logic                   mem_rd_en_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_a,
  output logic [DATA_W-1:0]      mem_d_out,
  output logic                   mem_d_drive,
  input  logic [DATA_W-1:0]      mem_d_in
);
  localparam int LANES = DATA_W / 8;
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RAS_LOW_BOUND = PAGE_LIMIT_CYC + CAS_LOW_CYC + CAS_HIGH_CYC + 4;

  function automatic logic [CNT_W-1:0] hold_of(input ctl_state_e s);
    case (s)
      ST_ACT:      return CNT_W'(span_to_load(RAS2CAS_CYC));
      ST_COL:      return CNT_W'(span_to_load(CAS_LOW_CYC));
      ST_CPRE:     return CNT_W'(span_to_load(CAS_HIGH_CYC));
      ST_PRE:      return CNT_W'(span_to_load(PRECH_CYC));
      ST_RF_SETUP: return CNT_W'(span_to_load(CBR_SETUP_CYC));
      ST_RF_LOW:   return CNT_W'(span_to_load(REF_LOW_CYC));
      ST_RF_REC:   return CNT_W'(span_to_load(PRECH_CYC));
      default:     return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  ctl_state_e st_q, st_d;
  logic t_zero, t_load, page_exp, row_hit, req_fire;
  logic [CNT_W-1:0] t_val;
  logic op_we_q;
  logic [LANES-1:0]  op_be_q;
  logic [DATA_W-1:0] op_wd_q;
  logic [MA_W-1:0]   open_row, cur_col;
  logic open_set, open_clr;

  // named internal events
  logic evt_open_hit;
  logic evt_read_done;

  assign req_ready = !ref_req &&
                     ((st_q == ST_IDLE) ||
                      (st_q == ST_OPEN && !page_exp && row_hit));
  assign req_fire      = req_valid && req_ready;
  assign evt_open_hit  = req_fire && (st_q == ST_OPEN);
  assign evt_read_done = (st_q == ST_CPRE) && t_zero && !op_we_q;
  assign open_set      = req_fire && (st_q == ST_IDLE);
  assign open_clr      = (st_q == ST_PRE) || (st_q == ST_RF_SETUP);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:     if (ref_req) st_d = ST_RF_SETUP;
                   else if (req_fire) st_d = ST_ACT;
      ST_ACT:      if (t_zero) st_d = ST_CSET;
      ST_CSET:     st_d = ST_COL;
      ST_COL:      if (t_zero) st_d = ST_CPRE;
      ST_CPRE:     if (t_zero) st_d = ST_OPEN;
      ST_OPEN:     if (ref_req || page_exp) st_d = ST_PRE;
                   else if (req_fire) st_d = ST_CSET;
                   else if (req_valid && !row_hit) st_d = ST_PRE;
      ST_PRE:      if (t_zero) st_d = ST_IDLE;
      ST_RF_SETUP: if (t_zero) st_d = ST_RF_LOW;
      ST_RF_LOW:   if (t_zero) st_d = ST_RF_REC;
      ST_RF_REC:   if (t_zero) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  assign t_load = (st_d != st_q);
  assign t_val  = hold_of(st_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_we_q  <= 1'b0;
      op_be_q  <= '0;
      op_wd_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      st_q <= st_d;
      if (req_fire) begin
        op_we_q <= req_we;
        op_be_q <= req_be;
        op_wd_q <= req_wdata;
      end
      rd_valid <= evt_read_done;
      if (evt_read_done) rd_data <= mem_d_in & lane_mask(op_be_q);
    end
  end

  edo_down_timer #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  edo_page_timer #(.LIMIT(PAGE_LIMIT_CYC)) u_page (
    .clk(clk), .rst_n(rst_n), .run(page_running(st_q)), .expired(page_exp)
  );

  edo_row_tracker #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .in_addr(req_addr), .cmd_latch(req_fire),
    .open_set(open_set), .open_clr(open_clr),
    .open_row(open_row), .cur_col(cur_col), .hit(row_hit)
  );

  assign ref_ack = (st_q == ST_RF_LOW) && t_zero;

  always_comb begin
    mem_row_stb_n = !row_is_low(st_q);
    mem_col_stb_n = '1;
    if (st_q == ST_COL) mem_col_stb_n = ~op_be_q;
    else if (st_q == ST_RF_SETUP || st_q == ST_RF_LOW) mem_col_stb_n = '0;
    mem_wr_n    = !(op_we_q && (st_q == ST_CSET || st_q == ST_COL));
    mem_rd_en_n = !(!op_we_q && (st_q == ST_COL || st_q == ST_CPRE));
    mem_d_drive = op_we_q && (st_q == ST_CSET || st_q == ST_COL);
    mem_d_out   = op_wd_q;
    case (st_q)
      ST_ACT:                    mem_a = open_row;
      ST_CSET, ST_COL, ST_CPRE:  mem_a = cur_col;
      default:                   mem_a = '0;
    endcase
  end

  // ---------------- assertions ----------------
  logic [LANES-1:0] col_q;
  logic [15:0]      row_low_run;
  logic             col_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q       <= '1;
      row_low_run <= '0;
    end else begin
      col_q       <= mem_col_stb_n;
      row_low_run <= mem_row_stb_n ? 16'd0 : row_low_run + 16'd1;
    end
  end
  assign col_fall = |(col_q & ~mem_col_stb_n);

  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_fall && !mem_wr_n) |-> $past(!mem_wr_n && &mem_col_stb_n)); // R3
  AST_READ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(&mem_col_stb_n)); // R6
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_ROW_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    row_low_run <= 16'(RAS_LOW_BOUND)); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_row_stb_n) && mem_col_stb_n == '0) |-> $past(mem_col_stb_n == '0)); // R8
  AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    evt_open_hit |=> !mem_row_stb_n); // R4
endmodule

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic        act;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 17'h00503, 4'hF, 32'hA1A2A3A4, 1'b1},
    '{1'b1, 17'h00504, 4'hF, 32'hB1B2B3B4, 1'b0},
    '{1'b0, 17'h00503, 4'hF, 32'hA1A2A3A4, 1'b0},
    '{1'b1, 17'h00503, 4'h5, 32'h11223344, 1'b0},
    '{1'b0, 17'h00503, 4'hF, 32'hA122A344, 1'b0},
    '{1'b0, 17'h00503, 4'hA, 32'hA100A300, 1'b0},
    '{1'b1, 17'h00903, 4'hF, 32'hC0C0C0C0, 1'b1},
    '{1'b0, 17'h00504, 4'hF, 32'hB1B2B3B4, 1'b1},
    '{1'b0, 17'h00903, 4'hF, 32'hC0C0C0C0, 1'b1},
    '{1'b1, 17'h1FFFF, 4'hF, 32'hDEADBEEF, 1'b1},
    '{1'b0, 17'h1FFFF, 4'hF, 32'hDEADBEEF, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [16:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_ack;
  logic [31:0] rd_data;
  logic mem_row_stb_n, mem_wr_n, mem_rd_en_n, mem_d_drive;
  logic [3:0] mem_col_stb_n;
  logic [8:0] mem_a;
  logic [31:0] mem_d_out;
  logic [31:0] mem_d_in = '0;

  int checks = 0, failures = 0, cyc = 0;

  edo_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
    .mem_row_stb_n(mem_row_stb_n), .mem_col_stb_n(mem_col_stb_n),
    .mem_wr_n(mem_wr_n), .mem_rd_en_n(mem_rd_en_n), .mem_a(mem_a),
    .mem_d_out(mem_d_out), .mem_d_drive(mem_d_drive), .mem_d_in(mem_d_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- memory model and monitors (falling edge) ----------------
  logic [31:0] mem [int];
  logic [8:0]  m_row = '0, m_col = '0;
  logic        p_row = 1'b1, p_wr = 1'b1;
  logic [3:0]  p_col = 4'hF, last_lanes = '0;
  int act_cnt = 0, cbr_cnt = 0, col_evt = 0, early_bad = 0, drive_bad = 0;
  int rcd_cnt = 0, last_rcd = -1, col_run = 0, last_col_run = -1;
  int hi_run = 0, min_hi = 1000;
  logic rcd_arm = 1'b0, seen_fall = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] fell;
      fell = p_col & ~mem_col_stb_n;
      if (mem_d_drive && !mem_rd_en_n) drive_bad++;
      if (p_row && !mem_row_stb_n) begin
        if (seen_fall && hi_run < min_hi) min_hi = hi_run;
        seen_fall = 1'b1;
        if (mem_col_stb_n == 4'h0 && p_col == 4'h0) cbr_cnt++;
        else begin
          act_cnt++; m_row = mem_a; rcd_arm = 1'b1; rcd_cnt = 0;
        end
      end else if (!mem_row_stb_n && rcd_arm) rcd_cnt++;
      hi_run = mem_row_stb_n ? hi_run + 1 : 0;
      if (fell != 4'h0 && !mem_row_stb_n) begin
        int key;
        logic [31:0] w;
        m_col = mem_a; col_evt++; last_lanes = fell;
        if (rcd_arm) begin last_rcd = rcd_cnt; rcd_arm = 1'b0; end
        key = int'({m_row, m_col[7:0]});
        w = mem.exists(key) ? mem[key] : 32'h0;
        for (int i = 0; i < 4; i++) if (fell[i]) begin
          if (!mem_wr_n) begin
            if (p_wr) early_bad++;
            w[i*8 +: 8] = mem_d_out[i*8 +: 8];
          end else mem_d_in[i*8 +: 8] = w[i*8 +: 8];
        end
        if (!mem_wr_n) mem[key] = w;
      end
      if (!mem_row_stb_n && mem_col_stb_n != 4'hF) col_run++;
      else if (col_run != 0) begin last_col_run = col_run; col_run = 0; end
      if (mem_row_stb_n || mem_rd_en_n) mem_d_in = 32'h0;
      p_row = mem_row_stb_n; p_col = mem_col_stb_n; p_wr = mem_wr_n;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [16:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic exp_act, input string tag);
    int a0, c0;
    a0 = act_cnt; c0 = col_evt;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    while (col_evt == c0) @(negedge clk);
    check({tag, " R2 lanes"}, 32'(last_lanes), 32'(be));
    check({tag, " R4/R5 row opening"}, 32'(act_cnt - a0), 32'(exp_act));
    if (!we) begin
      while (!rd_valid) @(negedge clk);
      check({tag, " R2/R6 read data"}, rd_data, d);
      check({tag, " R11 col low width"}, 32'(last_col_run), 32'd2);
      @(negedge clk);
      check({tag, " R6 single pulse"}, 32'(rd_valid), 32'd0);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rb_bad, c0, a0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 row strobe", 32'(mem_row_stb_n), 32'd1);
    check("R10 col strobes", 32'(mem_col_stb_n), 32'hF);
    check("R10 wr/oe", 32'({mem_wr_n, mem_rd_en_n}), 32'h3);
    check("R10 drive/rdvalid", 32'({mem_d_drive, rd_valid}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", 32'(req_ready), 32'd1);

    for (int v = 0; v < NV; v++)
      do_op(VEC[v].we, VEC[v].addr, VEC[v].be, VEC[v].data, VEC[v].act, $sformatf("vec%0d", v));

    check("R1 row latched", 32'(m_row), 32'h1FF);
    check("R1 column latched", 32'(m_col), 32'h0FF);
    check("R11 row-to-col delay", 32'(last_rcd), 32'd3);
    check("R5 precharge width", 32'(min_hi >= 3), 32'd1);
    check("R3 early write order", 32'(early_bad), 32'd0);
    check("R3 no drive while read enabled", 32'(drive_bad), 32'd0);

    // R7 page limit closes the idle row
    repeat (160) @(negedge clk);
    check("R7 row closed after limit", 32'(mem_row_stb_n), 32'd1);
    do_op(1'b0, 17'h1FFFF, 4'hF, 32'hDEADBEEF, 1'b1, "R7 reopen");

    // R8/R9 refresh with a competing hit request
    c0 = cbr_cnt; rb_bad = 0;
    @(negedge clk);
    ref_req = 1'b1; req_valid = 1'b1; req_we = 1'b0; req_addr = 17'h1FFFF; req_be = 4'hF;
    #1;
    while (!ref_ack) begin
      if (req_ready) rb_bad++;
      @(negedge clk); #1;
    end
    ref_req = 1'b0; req_valid = 1'b0;
    check("R9 ready held low", 32'(rb_bad), 32'd0);
    @(negedge clk);
    check("R8 column-first refresh", 32'(cbr_cnt - c0), 32'd1);
    a0 = act_cnt;
    do_op(1'b0, 17'h00903, 4'hF, 32'hC0C0C0C0, 1'b1, "R8 after refresh");
    check("R8 new row opening", 32'(act_cnt - a0), 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule